// File: doc/BRIEF.md
# Post-Divider with Test Output Selector

This block is the digital back end of a clock synthesizer. It counts edges from a fast source, given as a one-cycle enable pulse on the system clock, and turns them into a square-wave output. A 2-bit post-divide code sets how many source edges make up each half period. The ratio table is deliberately not in numeric order. A second counter, loaded with a feedback divide value, produces a short tick every M source edges.

A 3-bit test-select code controls a separate test output. That output can be held quiet, copy the divided main output, or show the feedback tick. One test-select value switches the block into bypass. In bypass, a slow external serial clock takes the place of the fast source for both counters. This lets a board drive the divider chain by hand during debug.

All state sits in the system clock domain. Divide values take effect only at a half-period boundary or at a tick, so a reprogramming never produces a runt pulse.

Top module: `postdiv_testmux`

## Requirements
- R1: While the active-low reset is asserted, both `out_q` and `test_q` are 0.
- R2: The post-divide code sets the number of selected source edges per half period of `out_q`: code 00 gives 2, code 01 gives 4, code 10 gives 8 and code 11 gives 1. A full output period is therefore twice that count.
- R3: `out_q` toggles on the first selected edge after reset. After that it toggles on every Nth selected edge. N is read from the code at each toggle, so a new code applies only from the next half period on.
- R4: When the test-select code is 110 (bypass), only `sclk_en` counts as a source edge and `vco_en` is ignored. For every other code, only `vco_en` counts and `sclk_en` is ignored.
- R5: Test-select code 000 holds `test_q` at 0.
- R6: With test-select code 110, `test_q` is high for exactly the one cycle after each Mth selected edge, starting with the first selected edge after reset. M is read from `m_val` at each tick.
- R7: An `m_val` of 0 behaves as M = 1: every selected edge produces a tick.
- R8: Test-select codes 001 to 101 make `test_q` equal to `out_q` in every cycle.
- R9: Test-select code 111 holds `test_q` at 0.
- R10: `out_q` changes only in the cycle after a selected source edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| vco_en | input | 1 | One-cycle pulse per fast-source edge |
| sclk_en | input | 1 | One-cycle pulse per external serial-clock edge |
| m_val | input | M_W | Feedback divide value (0 acts as 1) |
| n_code | input | 2 | Post-divide ratio code |
| t_code | input | 3 | Test output select code |
| out_q | output | 1 | Divided main output, 50% duty |
| test_q | output | 1 | Test output |

## Verification
If the post-divide counter is off by one, or misreads the ratio code, the main output's half period comes out wrong on the very next half period. The error therefore shows within at most eight selected edges. If source selection is wrong, the output moves on a pulse that should be ignored, which is visible one cycle later. A feedback counter that loads the wrong value, or mishandles zero, shows up in bypass as a tick at the wrong edge, again within one M period. The test-output multiplexer is compared against the expected node every cycle, so a decode error appears on the first cycle it is selected.

// File: rtl/pdv_pkg.sv
package pdv_pkg;

    localparam int N_MAX_RATIO = 8;
    localparam int NCNT_W      = $clog2(N_MAX_RATIO);

    localparam logic [2:0] TSEL_QUIET  = 3'b000;
    localparam logic [2:0] TSEL_BYPASS = 3'b110;
    localparam logic [2:0] TSEL_SPARE  = 3'b111;

    typedef enum logic [1:0] {
        TSRC_LOW   = 2'd0,
        TSRC_MAIN  = 2'd1,
        TSRC_MTICK = 2'd2
    } test_src_e;

    // Edges per half period for each post-divide code (non-sequential order).
    function automatic int half_ratio(input logic [1:0] code);
        case (code)
            2'b00:   return 2;
            2'b01:   return 4;
            2'b10:   return 8;
            default: return 1;
        endcase
    endfunction

    function automatic test_src_e test_src(input logic [2:0] code);
        if (code == TSEL_QUIET || code == TSEL_SPARE) return TSRC_LOW;
        if (code == TSEL_BYPASS)                      return TSRC_MTICK;
        return TSRC_MAIN;
    endfunction

endpackage

// File: rtl/pdv_ndiv.sv
module pdv_ndiv
    import pdv_pkg::*;
#(
    parameter int CNT_W = NCNT_W
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       step,
    input  logic [1:0] n_code,
    output logic       div_q,
    output logic       div_d
);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             div;
    } ndiv_st_t;

    ndiv_st_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (step) begin
            if (s_q.cnt == '0) begin
                // half-period boundary: toggle and pick up the current ratio
                s_d.div = ~s_q.div;
                s_d.cnt = CNT_W'(half_ratio(n_code) - 1);
            end else begin
                s_d.cnt = s_q.cnt - 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign div_q = s_q.div;
    assign div_d = s_d.div;

endmodule

// File: rtl/pdv_mdiv.sv
module pdv_mdiv #(
    parameter int M_W = 9
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           step,
    input  logic [M_W-1:0] m_val,
    output logic           tick
);

    typedef struct packed {
        logic [M_W-1:0] cnt;
    } mdiv_st_t;

    mdiv_st_t s_d, s_q;
    logic     wrap;

    always_comb begin
        s_d  = s_q;
        wrap = 1'b0;
        if (step) begin
            if (s_q.cnt == '0) begin
                wrap = 1'b1;
                // zero is folded onto a divide by one
                s_d.cnt = (m_val == '0) ? '0 : m_val - 1'b1;
            end else begin
                s_d.cnt = s_q.cnt - 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign tick = wrap;

endmodule

// File: rtl/pdv_testsel.sv
module pdv_testsel
    import pdv_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic [2:0] t_code,
    input  logic       main_d,
    input  logic       tick,
    output logic       test_q
);

    typedef struct packed {
        logic test;
    } tsel_st_t;

    tsel_st_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        unique case (test_src(t_code))
            TSRC_MAIN:  s_d.test = main_d;
            TSRC_MTICK: s_d.test = tick;
            default:    s_d.test = 1'b0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign test_q = s_q.test;

endmodule

// File: rtl/postdiv_testmux.sv
module postdiv_testmux
    import pdv_pkg::*;
#(
    parameter int M_W = 9
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           vco_en,
    input  logic           sclk_en,
    input  logic [M_W-1:0] m_val,
    input  logic [1:0]     n_code,
    input  logic [2:0]     t_code,
    output logic           out_q,
    output logic           test_q
);

    logic src_step;
    logic main_d;
    logic mtick;

    // bypass swaps the counting source for both dividers
    assign src_step = (t_code == TSEL_BYPASS) ? sclk_en : vco_en;

    pdv_ndiv #(.CNT_W(NCNT_W)) u_ndiv (
        .clk    (clk),
        .rst_n  (rst_n),
        .step   (src_step),
        .n_code (n_code),
        .div_q  (out_q),
        .div_d  (main_d)
    );

    pdv_mdiv #(.M_W(M_W)) u_mdiv (
        .clk   (clk),
        .rst_n (rst_n),
        .step  (src_step),
        .m_val (m_val),
        .tick  (mtick)
    );

    pdv_testsel u_tsel (
        .clk    (clk),
        .rst_n  (rst_n),
        .t_code (t_code),
        .main_d (main_d),
        .tick   (mtick),
        .test_q (test_q)
    );

endmodule

// File: rtl/pdv_checker.sv
module pdv_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       vco_en,
    input logic       sclk_en,
    input logic [2:0] t_code,
    input logic       out_q,
    input logic       test_q
);

    p_reset_quiet_r1: assert property (@(posedge clk)
        !rst_n |=> (!out_q && !test_q));

    p_vco_ignored_in_bypass_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (t_code == 3'b110 && !sclk_en) |=> $stable(out_q));

    p_hold_without_edge_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (t_code != 3'b110 && !vco_en) |=> $stable(out_q));

    p_quiet_test_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (t_code == 3'b000) |=> !test_q);

    p_spare_low_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (t_code == 3'b111) |=> !test_q);

    p_main_on_test_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (t_code >= 3'b001 && t_code <= 3'b101) |=> (test_q == out_q));

    p_tick_needs_edge_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (t_code == 3'b110 && !sclk_en) |=> !test_q);

endmodule

bind postdiv_testmux pdv_checker u_pdv_checker (
    .clk     (clk),
    .rst_n   (rst_n),
    .vco_en  (vco_en),
    .sclk_en (sclk_en),
    .t_code  (t_code),
    .out_q   (out_q),
    .test_q  (test_q)
);

// File: tb/postdiv_testmux_test.sv
module postdiv_testmux_test;

    localparam int M_W = 9;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic           vco_en = 1'b0;
    logic           sclk_en = 1'b0;
    logic [M_W-1:0] m_val = '0;
    logic [1:0]     n_code = 2'b00;
    logic [2:0]     t_code = 3'b000;
    logic           out_q;
    logic           test_q;

    int checks = 0;
    int errors = 0;
    string tag_ovr = "";

    // reference model state
    int  e_ncnt = 0;
    int  e_mcnt = 0;
    bit  e_out = 0;
    bit  e_tick = 0;
    bit  e_test = 0;

    always #10 clk = ~clk;

    postdiv_testmux #(.M_W(M_W)) uut (
        .clk (clk), .rst_n (rst_n), .vco_en (vco_en), .sclk_en (sclk_en),
        .m_val (m_val), .n_code (n_code), .t_code (t_code),
        .out_q (out_q), .test_q (test_q)
    );

    // R2 table: edges per half period
    function automatic int ratio_of(input logic [1:0] c);
        case (c)
            2'b00:   return 2;
            2'b01:   return 4;
            2'b10:   return 8;
            default: return 1;
        endcase
    endfunction

    function automatic string test_tag(input logic [2:0] t);
        if (t == 3'b000) return "R5";
        if (t == 3'b110) return "R6";
        if (t == 3'b111) return "R9";
        return "R8";
    endfunction

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic step();
        bit src;
        string to, tt;
        @(posedge clk);
        src = (t_code == 3'b110) ? sclk_en : vco_en;
        if (!rst_n) begin
            e_ncnt = 0; e_mcnt = 0; e_out = 0; e_tick = 0; e_test = 0;
        end else begin
            e_tick = 0;
            if (src) begin
                if (e_ncnt == 0) begin
                    e_out  = ~e_out;
                    e_ncnt = ratio_of(n_code) - 1;
                end else e_ncnt--;
                if (e_mcnt == 0) begin
                    e_tick = 1;
                    e_mcnt = (m_val == 0) ? 0 : int'(m_val) - 1;
                end else e_mcnt--;
            end
            if (t_code == 3'b000 || t_code == 3'b111) e_test = 0;
            else if (t_code == 3'b110)                e_test = e_tick;
            else                                       e_test = e_out;
        end
        to = (tag_ovr != "") ? tag_ovr : (src ? "R3" : "R10");
        tt = (tag_ovr != "") ? tag_ovr : test_tag(t_code);
        @(negedge clk);
        chk({to, " out_q"}, int'(out_q), int'(e_out));
        chk({tt, " test_q"}, int'(test_q), int'(e_test));
    endtask

    task automatic do_reset();
        tag_ovr = "R1";
        rst_n = 1'b0;
        step();
        step();
        rst_n = 1'b1;
        tag_ovr = "";
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'd4242));
        do_reset();

        // R2: half period length per code, continuous source edges
        for (int c = 0; c < 4; c++) begin
            int toggles, cyc;
            bit prev;
            do_reset();
            n_code = 2'(c); t_code = 3'b001; vco_en = 1'b1; sclk_en = 1'b0;
            toggles = 0; cyc = 0; prev = out_q;
            for (int k = 0; k < 40 && toggles < 2; k++) begin
                step();
                cyc++;
                if (out_q != prev) begin
                    toggles++;
                    if (toggles == 2) chk("R2 half period", cyc, ratio_of(2'(c)));
                    cyc = 0;
                    prev = out_q;
                end
            end
            chk("R2 toggles seen", toggles, 2);
        end

        // R3: ratio change mid half-period applies at next boundary
        do_reset();
        n_code = 2'b10; t_code = 3'b001; vco_en = 1'b1;
        step(); step(); step();
        n_code = 2'b11;
        repeat (12) step();

        // R4: bypass ignores vco_en; normal mode ignores sclk_en
        do_reset();
        tag_ovr = "R4";
        t_code = 3'b110; vco_en = 1'b1; sclk_en = 1'b0; n_code = 2'b11;
        repeat (10) step();
        t_code = 3'b010; vco_en = 1'b0; sclk_en = 1'b1;
        repeat (10) step();
        tag_ovr = "";

        // R7: m_val of zero ticks on every bypass edge
        do_reset();
        tag_ovr = "R7";
        t_code = 3'b110; m_val = '0; vco_en = 1'b0;
        for (int k = 0; k < 16; k++) begin
            sclk_en = k[0];
            step();
        end
        tag_ovr = "";

        // R6: bypass with M = 3
        do_reset();
        t_code = 3'b110; m_val = 9'd3; n_code = 2'b00;
        for (int k = 0; k < 30; k++) begin
            sclk_en = (k % 3) != 2;
            step();
        end

        // random phases covering R5, R8, R9 and mixed modes
        for (int ph = 0; ph < 40; ph++) begin
            if (ph % 10 == 0) do_reset();
            n_code = 2'($urandom % 4);
            m_val  = M_W'($urandom % 12);
            t_code = 3'($urandom % 8);
            for (int k = 0; k < 300; k++) begin
                vco_en  = ($urandom % 4) != 0;
                sclk_en = ($urandom % 3) == 0;
                if (k % 37 == 36) n_code = 2'($urandom % 4);
                if (k % 53 == 52) m_val  = M_W'($urandom % 12);
                step();
            end
        end

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule